// File: doc/BRIEF.md
# Two-Phase Modular Fibonacci Scrambler

This block scrambles a stream of 17-bit payloads (sixteen data bits plus a control/data flag) into 18-bit line words. It keeps two cross-coupled 19-bit accumulators, X and Y, which form a Fibonacci-style recurrence reduced modulo 254225 rather than 2^18. Each payload takes two clock phases.

In the accumulate phase, X takes the packed payload plus Y plus the stored carry of X. Y takes X plus Y plus the stored carry of Y. In the fix phase, each register has the correction constant 7919 (2^18 − 254225) added. The sum is written back only if that addition reaches bit 18, and bit 18 always records whether the reduction happened. The low 18 bits of X are the scrambled word.

Both stream edges use valid/ready. A payload is taken only in the accumulate phase. It is refused during the fix phase, and also while a finished word is waiting and the consumer is not ready. A finished word stays on the output, unchanged, until the consumer accepts it. With the consumer always ready, the block takes one payload every two cycles.

Top module: `modfib_scrambler`

## Requirements
- R1: A synchronous reset (`rst` high) clears X, Y, the phase and the pending result. After reset, `out_valid` is 0 and `in_ready` is 1. The first word scrambled after reset equals its packed payload.
- R2: The payload is packed as bits 7:0 = `in_data[7:0]`, bit 8 = `in_cd`, bits 16:9 = `in_data[15:8]`, and bit 17 = 0.
- R3: In the accumulate phase, both registers update from their old values: X ← payload + Y[17:0] + X[18], and Y ← X[17:0] + Y[17:0] + Y[18].
- R4: In the fix phase, t = X + 7919. X[18] ← t[18], and X[17:0] ← t[17:0] only when t[18] is 1. Y is updated the same way from u = Y + 7919.
- R5: `out_valid` rises two cycles after an accepted payload, and `out_word` is X[17:0] at that time. `out_valid` is low in the cycle right after acceptance.
- R6: `in_ready` is low in the fix phase. It is also low while `out_valid` is high and `out_ready` is low.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_word` holds its value.
- R8: Every presented `out_word`, and the Y state at that time, lies in 0 to 254224.
- R9: With `out_ready` held high, a new payload can be accepted in the same cycle the previous word is consumed. This gives one payload every two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Payload offered |
| in_ready | output | 1 | Payload can be taken this cycle |
| in_data | input | 16 | Payload data bits |
| in_cd | input | 1 | Control/data flag |
| out_valid | output | 1 | Scrambled word present |
| out_ready | input | 1 | Consumer takes the word this cycle |
| out_word | output | 18 | Scrambled word |

## Verification
The bench runs a long random stream, with and without output back-pressure. The aim is to push the registers past the modulus often. A design that drops the stored carry, or always writes the corrected sum, then drifts away from the model after the first reduction and can show out-of-range words. A payload packed directly after reset exposes a misplaced flag bit or a reset that leaves stale state. A stall held for several cycles while a new payload waits catches a design that overwrites the pending word or takes the payload twice. Back-to-back sends with a timed gap catch a sequencer that loses the same-cycle hand-over.

// File: rtl/modfib_pkg.sv
package modfib_pkg;
  localparam int DATA_W   = 16;
  localparam int WORD_W   = 18;
  localparam int FLAG_POS = 8;
  localparam int MODULUS  = 254225;
  localparam int REG_W    = WORD_W + 1;
  localparam int CORR     = (1 << WORD_W) - MODULUS;

  typedef enum logic {PH_ACC = 1'b0, PH_FIX = 1'b1} phase_e;
endpackage

// File: rtl/modfib_pack.sv
module modfib_pack #(
  parameter int DATA_W   = modfib_pkg::DATA_W,
  parameter int WORD_W   = modfib_pkg::WORD_W,
  parameter int FLAG_POS = modfib_pkg::FLAG_POS
) (
  input  logic [DATA_W-1:0] data,
  input  logic              flag,
  output logic [WORD_W-1:0] word
);
  // Data bits fill the word around the flag; bits above the payload stay 0.
  for (genvar i = 0; i < WORD_W; i++) begin : g_bit
    if (i < FLAG_POS) begin : g_lo
      assign word[i] = data[i];
    end else if (i == FLAG_POS) begin : g_flag
      assign word[i] = flag;
    end else if (i <= DATA_W) begin : g_hi
      assign word[i] = data[i-1];
    end else begin : g_zero
      assign word[i] = 1'b0;
    end
  end
endmodule

// File: rtl/modfib_lane.sv
module modfib_lane #(
  parameter int WORD_W = modfib_pkg::WORD_W,
  parameter int CORR   = modfib_pkg::CORR
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_acc,
  input  logic              step_fix,
  input  logic [WORD_W-1:0] op_a,
  input  logic [WORD_W-1:0] op_b,
  output logic [WORD_W:0]   q
);
  localparam int REG_W = WORD_W + 1;
  localparam logic [REG_W-1:0] CORR_V = REG_W'(CORR);

  logic [REG_W-1:0] acc_sum;
  logic [REG_W-1:0] fix_sum;

  // Accumulate: two operands plus the carry kept in the top bit.
  always_comb acc_sum = {1'b0, op_a} + {1'b0, op_b} + {{WORD_W{1'b0}}, q[WORD_W]};
  // Fix: trial add of the correction constant to the whole register.
  always_comb fix_sum = q + CORR_V;

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (step_acc) begin
      q <= acc_sum;
    end else if (step_fix) begin
      q[WORD_W] <= fix_sum[WORD_W];
      if (fix_sum[WORD_W]) q[WORD_W-1:0] <= fix_sum[WORD_W-1:0];
    end
  end
endmodule

// File: rtl/modfib_seq.sv
module modfib_seq (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic out_ready,
  output logic in_ready,
  output logic out_valid,
  output logic step_acc,
  output logic step_fix
);
  import modfib_pkg::*;

  phase_e phase_q;
  logic   pend_q;

  always_comb begin
    in_ready  = (phase_q == PH_ACC) && (!pend_q || out_ready);
    out_valid = pend_q;
    step_acc  = in_valid && in_ready;
    step_fix  = (phase_q == PH_FIX);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_ACC;
      pend_q  <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_ACC: begin
          if (step_acc) begin
            phase_q <= PH_FIX;
            pend_q  <= 1'b0;
          end else if (pend_q && out_ready) begin
            pend_q <= 1'b0;
          end
        end
        PH_FIX: begin
          phase_q <= PH_ACC;
          pend_q  <= 1'b1;
        end
        default: phase_q <= PH_ACC;
      endcase
    end
  end
endmodule

// File: rtl/modfib_scrambler.sv
module modfib_scrambler #(
  parameter int DATA_W   = modfib_pkg::DATA_W,
  parameter int WORD_W   = modfib_pkg::WORD_W,
  parameter int FLAG_POS = modfib_pkg::FLAG_POS,
  parameter int MODULUS  = modfib_pkg::MODULUS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_cd,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_word
);
  localparam int CORR = (1 << WORD_W) - MODULUS;

  logic [WORD_W-1:0] msg;
  logic [WORD_W:0]   x_q;
  logic [WORD_W:0]   y_q;
  logic              step_acc;
  logic              step_fix;

  modfib_pack #(.DATA_W(DATA_W), .WORD_W(WORD_W), .FLAG_POS(FLAG_POS)) u_pack (
    .data(in_data), .flag(in_cd), .word(msg)
  );

  modfib_seq u_seq (
    .clk(clk), .rst(rst), .in_valid(in_valid), .out_ready(out_ready),
    .in_ready(in_ready), .out_valid(out_valid),
    .step_acc(step_acc), .step_fix(step_fix)
  );

  // X folds in the payload; Y folds in X. Both read the old register values.
  modfib_lane #(.WORD_W(WORD_W), .CORR(CORR)) u_lane_x (
    .clk(clk), .rst(rst), .step_acc(step_acc), .step_fix(step_fix),
    .op_a(msg), .op_b(y_q[WORD_W-1:0]), .q(x_q)
  );

  modfib_lane #(.WORD_W(WORD_W), .CORR(CORR)) u_lane_y (
    .clk(clk), .rst(rst), .step_acc(step_acc), .step_fix(step_fix),
    .op_a(x_q[WORD_W-1:0]), .op_b(y_q[WORD_W-1:0]), .q(y_q)
  );

  assign out_word = x_q[WORD_W-1:0];
endmodule

// File: rtl/modfib_scrambler_chk.sv
module modfib_scrambler_chk #(
  parameter int WORD_W  = modfib_pkg::WORD_W,
  parameter int MODULUS = modfib_pkg::MODULUS
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_word,
  input logic [WORD_W:0]   y_state
);
  assert_fix_busy_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);

  assert_stall_busy_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  assert_latency_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !out_valid ##1 out_valid);

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));

  assert_out_range_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (int'(out_word) < MODULUS));

  assert_y_reduced_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (int'(y_state[WORD_W-1:0]) < MODULUS));
endmodule

bind modfib_scrambler modfib_scrambler_chk #(.WORD_W(WORD_W), .MODULUS(MODULUS)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
  .y_state(y_q)
);

// File: tb/modfib_scrambler_tb.sv
module modfib_scrambler_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic        in_cd = 1'b0;
  logic        out_ready = 1'b0;
  logic        in_ready;
  logic        out_valid;
  logic [17:0] out_word;

  int n_cmp = 0;
  int n_bad = 0;
  int ready_mode = 0;
  int cyc = 0;
  int last_acc = -1;
  int acc_gap = 0;
  int n_reduce = 0;
  bit finished = 0;
  logic [18:0] mx = '0;
  logic [18:0] my = '0;
  logic [17:0] expq[$];
  logic [17:0] hold;

  modfib_scrambler u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_cd(in_cd), .out_valid(out_valid),
    .out_ready(out_ready), .out_word(out_word)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    #2;
    case (ready_mode)
      0:       out_ready <= 1'b1;
      1:       out_ready <= 1'($urandom % 2);
      default: out_ready <= 1'b0;
    endcase
  end

  task automatic chk(bit ok, string req, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R2 layout: {0, data[15:8], flag, data[7:0]}
  function automatic logic [17:0] packw(logic [15:0] d, logic f);
    return {1'b0, d[15:8], f, d[7:0]};
  endfunction

  // Two-phase recurrence of R3 and R4.
  task automatic model_step(logic [17:0] m);
    logic [18:0] nx, ny, t, u;
    nx = {1'b0, m} + {1'b0, my[17:0]} + {18'd0, mx[18]};
    ny = {1'b0, mx[17:0]} + {1'b0, my[17:0]} + {18'd0, my[18]};
    t = nx + 19'd7919;
    u = ny + 19'd7919;
    mx = t[18] ? t : {1'b0, nx[17:0]};
    my = u[18] ? u : {1'b0, ny[17:0]};
    if (t[18]) n_reduce++;
    expq.push_back(mx[17:0]);
  endtask

  // Called at a falling edge; returns at the falling edge after acceptance.
  task automatic send(logic [15:0] d, logic f);
    in_valid = 1'b1;
    in_data  = d;
    in_cd    = f;
    while (!in_ready) @(negedge clk);
    model_step(packw(d, f));
    acc_gap  = cyc - last_acc;
    last_acc = cyc;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // Scoreboard monitor.
  always @(negedge clk) begin
    logic [17:0] e;
    if (!rst && out_valid && out_ready) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R5 word with nothing expected", int'(out_word), 0);
      end else begin
        e = expq.pop_front();
        chk(out_word == e, "R3/R4 scrambled word", int'(out_word), int'(e));
        chk(int'(out_word) < 254225, "R8 word range", int'(out_word), 254224);
      end
    end
  end

  task automatic finish_run();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog R6 handshake stalled actual=%0d expected=%0d", cyc, 0);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid during reset", int'(out_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);

    // R2 / R5: first word from cleared state
    send(16'hABCD, 1'b1);
    in_valid = 1'b0;
    chk(out_valid == 1'b0, "R5 early valid", int'(out_valid), 0);
    chk(in_ready == 1'b0, "R6 ready in fix phase", int'(in_ready), 0);
    @(negedge clk);
    chk(out_valid == 1'b1, "R5 valid after two cycles", int'(out_valid), 1);
    chk(out_word == 18'h157CD, "R2 packing", int'(out_word), 'h157CD);
    idle(2);

    // R9: back-to-back acceptance
    send(16'h0001, 1'b0);
    send(16'h0002, 1'b1);
    chk(acc_gap == 2, "R9 acceptance gap", acc_gap, 2);
    send(16'h0003, 1'b0);
    chk(acc_gap == 2, "R9 acceptance gap", acc_gap, 2);
    idle(3);

    // R6 / R7: output stall with a waiting payload
    ready_mode = 2;
    idle(2);
    send(16'h1234, 1'b0);
    in_valid = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b1, "R7 stalled word present", int'(out_valid), 1);
    hold = out_word;
    in_valid = 1'b1;
    in_data  = 16'h5555;
    in_cd    = 1'b1;
    repeat (4) begin
      @(negedge clk);
      chk(out_valid && out_word == hold, "R7 word held", int'(out_word), int'(hold));
      chk(in_ready == 1'b0, "R6 ready while stalled", int'(in_ready), 0);
    end
    ready_mode = 0;
    send(16'h5555, 1'b1);
    idle(4);

    // Random stream with random back-pressure, then without
    ready_mode = 1;
    for (int i = 0; i < 400; i++) begin
      send(16'($urandom), 1'($urandom % 2));
      if ($urandom % 4 == 0) idle(1 + $urandom % 3);
    end
    ready_mode = 0;
    for (int i = 0; i < 400; i++) send(16'($urandom), 1'($urandom % 2));
    idle(1);
    for (int i = 0; i < 50 && expq.size() != 0; i++) @(negedge clk);
    chk(expq.size() == 0, "R5 all words delivered", expq.size(), 0);
    chk(n_reduce > 0, "R4 reductions exercised", n_reduce, 1);

    // R1: reset in mid-stream clears state
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid in second reset", int'(out_valid), 0);
    rst = 1'b0;
    mx = '0;
    my = '0;
    @(negedge clk);
    send(16'hABCD, 1'b1);
    in_valid = 1'b0;
    @(negedge clk);
    chk(out_valid && out_word == 18'h157CD, "R1 state cleared by reset", int'(out_word), 'h157CD);
    idle(3);
    finish_run();
  end
endmodule